// File: doc/BRIEF.md
# NAND Flash Micro-Operation Sequencer

This block sits between a host and a raw asynchronous NAND flash device. The host pushes encoded command words into a 32-entry queue. The sequencer pops the words one at a time and turns each into activity on the flash pins: command latch cycles, address latch cycles, single-byte writes and single-byte reads. It also handles idle pauses and waits on the ready/busy line. The host pushes a whole operation and leaves it to run; it does not toggle pins itself.

The block enforces the flash timing itself. Every bus cycle has a programmable setup phase, a strobe pulse width and a hold phase. A read that follows a command cycle is held back until a command-to-read turnaround has passed. A ready/busy wait does not sample the line until a write-to-busy delay has elapsed after the last command or address strobe. Busy waits run in hardware and have a timeout. When the timeout expires, a sticky error flag is set and the sequencer moves on to the next word. Bytes read from the flash collect in a small output FIFO that the host drains.

All timing values are given in clock cycles. They must be held stable while the queue holds work.

Top module: `nandseq_top`

## Requirements
- R1: After reset, both strobes are high, every chip enable is high, the latch enables are low, done is 1, qFull is 0, timeoutErr is 0 and rdValid is 0.
- R2: Command word fields: bits [7:0] are the payload, bits [10:8] are the operation code (0 command, 1 address, 2 write byte, 3 read byte, 4 idle, 5 wait-ready; codes 6 and 7 are skipped), and bits [12:11] select the chip. A command word yields one write strobe with nandCle high, nandAle low, the payload on nandIoOut, nandIoOe high, the selected chip enable low and all the others high.
- R3: An address word yields one write strobe with nandAle high and nandCle low. Consecutive address words appear on the bus in queue order.
- R4: Each bus cycle keeps its latch enable high for cfgSetup+cfgPulse+cfgHold clocks, and the strobe is low for exactly cfgPulse clocks.
- R5: A write-byte word yields one write strobe with both latch enables low and the payload on the bus.
- R6: A read-byte word drops nandReN for cfgPulse clocks with nandIoOe low. The value on nandIoIn just before nandReN rises is appended to the read FIFO, which presents it on rdData while rdValid is 1 and advances it on rdPop.
- R7: At least cfgTwhr clocks pass from the rising write strobe of a command cycle to the falling read strobe of a following read word.
- R8: An idle word with payload N adds exactly N+1 clocks between the neighbouring bus cycles, compared with the same words queued without it.
- R9: After a wait-ready word, the next bus cycle starts no sooner than cfgTwb clocks after the rising write strobe of the preceding command or address cycle.
- R10: While nandRb is low, a wait-ready word blocks every later word and done stays 0. The sequencer resumes only after nandRb goes high.
- R11: If nandRb stays low for cfgTimeout clocks during a wait, timeoutErr becomes 1 and stays 1 until reset, and the next word then executes.
- R12: The queue holds 32 words. qFull is 1 when it is full, and a push while it is full is dropped.
- R13: done is 1 only when the queue is empty and no word is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgSetup | input | 8 | Latch-to-strobe setup, clocks |
| cfgPulse | input | 8 | Strobe low width, clocks |
| cfgHold | input | 8 | Hold after strobe rise, clocks |
| cfgTwhr | input | 8 | Command-to-read turnaround, clocks |
| cfgTwb | input | 8 | Strobe-to-busy-sample delay, clocks |
| cfgTimeout | input | 16 | Ready wait limit, clocks |
| qPush | input | 1 | Push qWord into the queue |
| qWord | input | 13 | Encoded command word |
| qFull | output | 1 | Queue full |
| rdPop | input | 1 | Consume the read FIFO head |
| rdValid | output | 1 | Read FIFO non-empty |
| rdData | output | 8 | Read FIFO head byte |
| done | output | 1 | Queue empty and sequencer idle |
| timeoutErr | output | 1 | Sticky ready-wait timeout |
| nandCeN | output | 4 | Active-low chip enables |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Write strobe, active low |
| nandReN | output | 1 | Read strobe, active low |
| nandIoOut | output | 8 | Bus data out |
| nandIoOe | output | 1 | Bus output enable |
| nandIoIn | input | 8 | Bus data in |
| nandRb | input | 1 | Ready (1) / busy (0) |

## Verification
On every cycle, the assertions check the following: at most one chip enable is active, and the two strobes are never low together. The bus is never driven while the read strobe is low. No read strobe starts before the turnaround counter has expired. Ready is never sampled before the busy delay has expired. The timeout flag never clears, and the queue never overflows. Only the bench scenarios can show the rest, by timing and decoding pin activity: field decoding, address order, exact pulse and latch widths, the idle length, read data returning through the FIFO, blocking on busy and resuming when ready, the dropped push and the done flag.

// File: rtl/nandseq_pkg.sv
package nandseq_pkg;
  localparam logic [2:0] OP_CMD   = 3'd0;
  localparam logic [2:0] OP_ADDR  = 3'd1;
  localparam logic [2:0] OP_WRITE = 3'd2;
  localparam logic [2:0] OP_READ  = 3'd3;
  localparam logic [2:0] OP_IDLE  = 3'd4;
  localparam logic [2:0] OP_WAIT  = 3'd5;

  typedef struct packed {
    logic load;     // latch head word fields
    logic busOn;    // chip enable active
    logic cleOn;
    logic aleOn;
    logic weLow;
    logic reLow;
    logic ioDrive;
    logic capture;  // last read-pulse cycle
  } strobes_t;
endpackage

// File: rtl/nandseq_fifo.sv
module nandseq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] CAP = (AW+1)'(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wrPtr, rdPtr, count;

  assign count = wrPtr - rdPtr;
  assign full  = (count == CAP);
  assign empty = (count == '0);
  assign head  = mem[rdPtr[AW-1:0]];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (push && !full) wrPtr <= wrPtr + 1'b1;
      if (pop && !empty) rdPtr <= rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) mem[wrPtr[AW-1:0]] <= din;
  end

  // R12: a push into a full queue leaves the occupancy unchanged
  a_r12_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (full && push && !pop) |=> (count == $past(count)));
  a_r12_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= CAP);
endmodule

// File: rtl/nandseq_ctrl.sv
module nandseq_ctrl
  import nandseq_pkg::*;
#(
  parameter int TW  = 8,
  parameter int TOW = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [2:0]     headOp,
  input  logic [7:0]     headPayload,
  input  logic           qEmpty,
  input  logic           rdFull,
  input  logic           nandRb,
  input  logic [TW-1:0]  cfgSetup,
  input  logic [TW-1:0]  cfgPulse,
  input  logic [TW-1:0]  cfgHold,
  input  logic [TW-1:0]  cfgTwhr,
  input  logic [TW-1:0]  cfgTwb,
  input  logic [TOW-1:0] cfgTimeout,
  output logic           qPop,
  output strobes_t       stb,
  output logic           done,
  output logic           timeoutErr
);
  localparam int CW = (TW > 8) ? TW : 8;

  typedef enum logic [2:0] {
    S_FETCH, S_GAP, S_SETUP, S_PULSE, S_HOLD, S_DELAY, S_TWB, S_WAITRB
  } state_e;

  state_e         state, nxtState;
  logic [CW-1:0]  cnt, nxtCnt;
  logic [2:0]     curOp;
  logic [TW-1:0]  whrCnt, wbCnt;
  logic [TOW-1:0] toCnt;
  logic [1:0]     rbSync;
  logic           errSet, pulseEnd;

  function automatic logic [CW-1:0] phaseLen(input logic [TW-1:0] v);
    return (v == '0) ? '0 : (CW'(v) - CW'(1));
  endfunction

  assign pulseEnd = (state == S_PULSE) && (cnt == '0);
  assign done     = qEmpty && (state == S_FETCH);

  always_comb begin
    nxtState = state;
    nxtCnt   = (cnt != '0) ? cnt - 1'b1 : cnt;
    qPop     = 1'b0;
    errSet   = 1'b0;
    stb      = '0;
    unique case (state)
      S_FETCH: begin
        if (!qEmpty && !(headOp == OP_READ && rdFull)) begin
          qPop     = 1'b1;
          stb.load = 1'b1;
          case (headOp)
            OP_CMD, OP_ADDR, OP_WRITE: begin
              nxtState = S_SETUP;
              nxtCnt   = phaseLen(cfgSetup);
            end
            OP_READ: begin
              nxtState = (whrCnt != '0) ? S_GAP : S_SETUP;
              nxtCnt   = phaseLen(cfgSetup);
            end
            OP_IDLE: begin
              if (headPayload != 8'd0) begin
                nxtState = S_DELAY;
                nxtCnt   = CW'(headPayload) - CW'(1);
              end
            end
            OP_WAIT: nxtState = S_TWB;
            default: nxtState = S_FETCH;
          endcase
        end
      end
      S_GAP: begin
        stb.busOn = 1'b1;
        nxtCnt    = cnt;
        if (whrCnt == '0) nxtState = S_SETUP;
      end
      S_SETUP: if (cnt == '0) begin
        nxtState = S_PULSE;
        nxtCnt   = phaseLen(cfgPulse);
      end
      S_PULSE: if (cnt == '0) begin
        nxtState = S_HOLD;
        nxtCnt   = phaseLen(cfgHold);
      end
      S_HOLD:  if (cnt == '0) nxtState = S_FETCH;
      S_DELAY: if (cnt == '0) nxtState = S_FETCH;
      S_TWB:   if (wbCnt == '0) nxtState = S_WAITRB;
      S_WAITRB: begin
        if (rbSync[1]) begin
          nxtState = S_FETCH;
        end else if ((toCnt + TOW'(1)) >= cfgTimeout) begin
          nxtState = S_FETCH;
          errSet   = 1'b1;
        end
      end
      default: nxtState = S_FETCH;
    endcase
    if (state == S_SETUP || state == S_PULSE || state == S_HOLD) begin
      stb.busOn   = 1'b1;
      stb.cleOn   = (curOp == OP_CMD);
      stb.aleOn   = (curOp == OP_ADDR);
      stb.ioDrive = (curOp != OP_READ);
      stb.weLow   = (state == S_PULSE) && (curOp != OP_READ);
      stb.reLow   = (state == S_PULSE) && (curOp == OP_READ);
      stb.capture = pulseEnd && (curOp == OP_READ);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_FETCH;
      cnt        <= '0;
      curOp      <= OP_CMD;
      whrCnt     <= '0;
      wbCnt      <= '0;
      toCnt      <= '0;
      rbSync     <= '0;
      timeoutErr <= 1'b0;
    end else begin
      state  <= nxtState;
      cnt    <= nxtCnt;
      rbSync <= {rbSync[0], nandRb};
      if (stb.load) curOp <= headOp;
      if (pulseEnd && curOp == OP_CMD) whrCnt <= cfgTwhr;
      else if (whrCnt != '0)            whrCnt <= whrCnt - 1'b1;
      if (pulseEnd && (curOp == OP_CMD || curOp == OP_ADDR)) wbCnt <= cfgTwb;
      else if (wbCnt != '0)                                  wbCnt <= wbCnt - 1'b1;
      toCnt <= (state == S_WAITRB) ? toCnt + 1'b1 : '0;
      if (errSet) timeoutErr <= 1'b1;
    end
  end

  // R7: the read strobe never starts while the turnaround is still running
  a_r7_whr_met: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_PULSE && curOp == OP_READ) |-> (whrCnt == '0));
  // R9: ready is sampled only after the busy delay has run out
  a_r9_twb_met: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAITRB) |-> (wbCnt == '0));
  // R11: the timeout flag is sticky
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |=> timeoutErr);
endmodule

// File: rtl/nandseq_dpath.sv
module nandseq_dpath
  import nandseq_pkg::*;
#(
  parameter int CS_W = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobes_t              stb,
  input  logic [CS_W-1:0]       headCs,
  input  logic [7:0]            headPayload,
  input  logic [7:0]            nandIoIn,
  output logic                  rdPush,
  output logic [7:0]            rdByte,
  output logic [(1<<CS_W)-1:0]  nandCeN,
  output logic                  nandCle,
  output logic                  nandAle,
  output logic                  nandWeN,
  output logic                  nandReN,
  output logic [7:0]            nandIoOut,
  output logic                  nandIoOe
);
  localparam int NUM_CE = 1 << CS_W;

  logic [CS_W-1:0] csReg;
  logic [7:0]      dataReg;
  logic            capDly;

  assign rdPush = capDly;
  assign rdByte = nandIoIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csReg     <= '0;
      dataReg   <= '0;
      capDly    <= 1'b0;
      nandCeN   <= '1;
      nandCle   <= 1'b0;
      nandAle   <= 1'b0;
      nandWeN   <= 1'b1;
      nandReN   <= 1'b1;
      nandIoOut <= '0;
      nandIoOe  <= 1'b0;
    end else begin
      if (stb.load) begin
        csReg   <= headCs;
        dataReg <= headPayload;
      end
      capDly    <= stb.capture;
      nandCeN   <= stb.busOn ? ~(NUM_CE'(1) << csReg) : '1;
      nandCle   <= stb.busOn && stb.cleOn;
      nandAle   <= stb.busOn && stb.aleOn;
      nandWeN   <= !stb.weLow;
      nandReN   <= !stb.reLow;
      nandIoOut <= stb.ioDrive ? dataReg : '0;
      nandIoOe  <= stb.busOn && stb.ioDrive;
    end
  end

  // R2: never more than one chip selected
  a_r2_one_chip: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~nandCeN));
  // R6: strobes exclusive, bus released during a read strobe
  a_r6_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(!nandWeN && !nandReN));
  a_r6_no_drive_read: assert property (@(posedge clk) disable iff (!rstN)
    !nandReN |-> !nandIoOe);
endmodule

// File: rtl/nandseq_top.sv
module nandseq_top
  import nandseq_pkg::*;
#(
  parameter int CS_W   = 2,
  parameter int QDEPTH = 32,
  parameter int RDEPTH = 8,
  parameter int TW     = 8,
  parameter int TOW    = 16,
  localparam int WORD_W = 8 + 3 + CS_W,
  localparam int NUM_CE = 1 << CS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TW-1:0]     cfgSetup,
  input  logic [TW-1:0]     cfgPulse,
  input  logic [TW-1:0]     cfgHold,
  input  logic [TW-1:0]     cfgTwhr,
  input  logic [TW-1:0]     cfgTwb,
  input  logic [TOW-1:0]    cfgTimeout,
  input  logic              qPush,
  input  logic [WORD_W-1:0] qWord,
  output logic              qFull,
  input  logic              rdPop,
  output logic              rdValid,
  output logic [7:0]        rdData,
  output logic              done,
  output logic              timeoutErr,
  output logic [NUM_CE-1:0] nandCeN,
  output logic              nandCle,
  output logic              nandAle,
  output logic              nandWeN,
  output logic              nandReN,
  output logic [7:0]        nandIoOut,
  output logic              nandIoOe,
  input  logic [7:0]        nandIoIn,
  input  logic              nandRb
);
  logic [WORD_W-1:0] head;
  logic              qEmpty, qPop, rdFull, rdEmpty, rdPush;
  logic [7:0]        rdByte;
  strobes_t          stb;

  nandseq_fifo #(.W(WORD_W), .DEPTH(QDEPTH)) u_cmdq (
    .clk(clk), .rstN(rstN), .push(qPush), .din(qWord), .pop(qPop),
    .head(head), .full(qFull), .empty(qEmpty));

  nandseq_ctrl #(.TW(TW), .TOW(TOW)) u_ctrl (
    .clk(clk), .rstN(rstN), .headOp(head[10:8]), .headPayload(head[7:0]),
    .qEmpty(qEmpty), .rdFull(rdFull), .nandRb(nandRb),
    .cfgSetup(cfgSetup), .cfgPulse(cfgPulse), .cfgHold(cfgHold),
    .cfgTwhr(cfgTwhr), .cfgTwb(cfgTwb), .cfgTimeout(cfgTimeout),
    .qPop(qPop), .stb(stb), .done(done), .timeoutErr(timeoutErr));

  nandseq_dpath #(.CS_W(CS_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .headCs(head[WORD_W-1:11]),
    .headPayload(head[7:0]), .nandIoIn(nandIoIn), .rdPush(rdPush),
    .rdByte(rdByte), .nandCeN(nandCeN), .nandCle(nandCle),
    .nandAle(nandAle), .nandWeN(nandWeN), .nandReN(nandReN),
    .nandIoOut(nandIoOut), .nandIoOe(nandIoOe));

  nandseq_fifo #(.W(8), .DEPTH(RDEPTH)) u_rdq (
    .clk(clk), .rstN(rstN), .push(rdPush), .din(rdByte), .pop(rdPop),
    .head(rdData), .full(rdFull), .empty(rdEmpty));

  assign rdValid = !rdEmpty;
endmodule

// File: tb/tb_nandseq_top.sv
`timescale 1ns/1ps
module tb_nandseq_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  cfgSetup = 8'd2, cfgPulse = 8'd3, cfgHold = 8'd2;
  logic [7:0]  cfgTwhr = 8'd20, cfgTwb = 8'd15;
  logic [15:0] cfgTimeout = 16'd1000;
  logic        qPush = 1'b0, rdPop = 1'b0, nandRb = 1'b1;
  logic [12:0] qWord = '0;
  logic [7:0]  nandIoIn = '0;
  logic        qFull, rdValid, done, timeoutErr;
  logic [7:0]  rdData, nandIoOut;
  logic [3:0]  nandCeN;
  logic        nandCle, nandAle, nandWeN, nandReN, nandIoOe;

  nandseq_top dut (.*);

  always #2.5 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  int evCnt = 0, reCnt = 0;
  int evFall[128], evRise[128], reFall[16], reWidth[16];
  logic [7:0] evIo[128];
  logic [3:0] evCe[128];
  logic evCle[128], evAle[128], evOe[128];
  logic [7:0] readSrc[16];
  int weFallC, cleRiseC, aleRiseC, cleLen, aleLen;
  logic pWe = 1, pRe = 1, pCle = 0, pAle = 0, oeOnRead = 0;
  logic lCle, lAle, lOe;
  logic [7:0] lIo;
  logic [3:0] lCe;

  // pin monitor and flash read model
  always @(negedge clk) begin
    cyc++;
    if (!nandWeN && pWe) weFallC = cyc;
    if (!nandWeN) begin lCle = nandCle; lAle = nandAle; lIo = nandIoOut; lCe = nandCeN; lOe = nandIoOe; end
    if (nandWeN && !pWe) begin
      evFall[evCnt] = weFallC; evRise[evCnt] = cyc; evCle[evCnt] = lCle;
      evAle[evCnt] = lAle; evIo[evCnt] = lIo; evCe[evCnt] = lCe; evOe[evCnt] = lOe;
      evCnt++;
    end
    if (nandCle && !pCle) cleRiseC = cyc;
    if (!nandCle && pCle) cleLen = cyc - cleRiseC;
    if (nandAle && !pAle) aleRiseC = cyc;
    if (!nandAle && pAle) aleLen = cyc - aleRiseC;
    if (!nandReN && pRe) begin reFall[reCnt] = cyc; nandIoIn = readSrc[reCnt]; end
    if (!nandReN && nandIoOe) oeOnRead = 1;
    if (nandReN && !pRe) begin reWidth[reCnt] = cyc - reFall[reCnt]; reCnt++; end
    pWe = nandWeN; pRe = nandReN; pCle = nandCle; pAle = nandAle;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [12:0] mk(input int cs, input int op, input int pl);
    return {cs[1:0], op[2:0], pl[7:0]};
  endfunction

  task automatic push(input logic [12:0] w);
    @(negedge clk); qPush = 1'b1; qWord = w;
    @(negedge clk); qPush = 1'b0;
  endtask

  task automatic waitDone();
    for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(nandWeN && nandReN, "R1 strobes", {nandWeN, nandReN}, 3);
    chk(nandCeN == 4'hF && !nandCle && !nandAle, "R1 enables", nandCeN, 15);
    chk(done && !qFull && !timeoutErr && !rdValid, "R1 flags",
        {done, qFull, timeoutErr, rdValid}, 8);
  endtask

  task automatic t_cmdAddrWrite();
    int b = evCnt;
    push(mk(1, 0, 'h80)); push(mk(1, 1, 'h11)); push(mk(1, 1, 'h22));
    push(mk(1, 1, 'h33)); push(mk(1, 2, 'h5A));
    waitDone();
    chk(evCnt - b == 5, "R2 strobe count", evCnt - b, 5);
    chk(evCle[b] && !evAle[b] && evIo[b] == 8'h80 && evOe[b], "R2 command cycle", evIo[b], 'h80);
    chk(evCe[b] == 4'b1101, "R2 chip select", evCe[b], 4'b1101);
    chk(evAle[b+1] && !evCle[b+1] && evIo[b+1] == 8'h11 && evIo[b+2] == 8'h22
        && evIo[b+3] == 8'h33, "R3 address order", evIo[b+3], 'h33);
    chk(!evCle[b+4] && !evAle[b+4] && evIo[b+4] == 8'h5A, "R5 write byte", evIo[b+4], 'h5A);
    chk(evRise[b] - evFall[b] == 3, "R4 pulse width", evRise[b] - evFall[b], 3);
    chk(cleLen == 7, "R4 cle span", cleLen, 7);
    chk(aleLen == 7, "R4 ale span", aleLen, 7);
  endtask

  task automatic t_read();
    int b = evCnt, r = reCnt;
    readSrc[r] = 8'hA5; readSrc[r+1] = 8'h3C;
    push(mk(0, 0, 'h70)); push(mk(0, 3, 0)); push(mk(0, 3, 0));
    waitDone();
    chk(reCnt - r == 2, "R6 read strobes", reCnt - r, 2);
    chk(reWidth[r] == 3, "R6 read width", reWidth[r], 3);
    chk(!oeOnRead, "R6 bus released", oeOnRead, 0);
    chk(reFall[r] - evRise[b] >= 20, "R7 turnaround", reFall[r] - evRise[b], 20);
    chk(rdValid && rdData == 8'hA5, "R6 first byte", rdData, 'hA5);
    @(negedge clk); rdPop = 1'b1; @(negedge clk); rdPop = 1'b0;
    chk(rdValid && rdData == 8'h3C, "R6 second byte", rdData, 'h3C);
    @(negedge clk); rdPop = 1'b1; @(negedge clk); rdPop = 1'b0;
    chk(!rdValid, "R6 fifo drained", rdValid, 0);
  endtask

  task automatic t_idle();
    int b = evCnt, g0, g1;
    push(mk(0, 0, 1)); push(mk(0, 0, 2));
    waitDone();
    g0 = evFall[b+1] - evRise[b];
    b = evCnt;
    push(mk(0, 0, 1)); push(mk(0, 4, 40)); push(mk(0, 0, 2));
    waitDone();
    g1 = evFall[b+1] - evRise[b];
    chk(g1 - g0 == 41, "R8 idle length", g1 - g0, 41);
  endtask

  task automatic t_twb();
    int b = evCnt;
    push(mk(2, 1, 'h44)); push(mk(2, 5, 0)); push(mk(2, 0, 'h55));
    waitDone();
    chk(evFall[b+1] - evRise[b] >= 15, "R9 busy delay", evFall[b+1] - evRise[b], 15);
  endtask

  task automatic t_waitBusy();
    int b = evCnt, rel;
    cfgTimeout = 16'd1000; nandRb = 1'b0;
    push(mk(0, 0, 'h60)); push(mk(0, 5, 0)); push(mk(0, 0, 'hD0));
    repeat (100) @(negedge clk);
    chk(evCnt - b == 1, "R10 blocked while busy", evCnt - b, 1);
    chk(!done, "R13 not done while waiting", done, 0);
    nandRb = 1'b1; rel = cyc;
    waitDone();
    chk(evCnt - b == 2 && evFall[b+1] > rel, "R10 resume after ready", evFall[b+1] - rel, 1);
    chk(done, "R13 done when idle", done, 1);
  endtask

  task automatic t_timeout();
    int b = evCnt;
    cfgTimeout = 16'd50; nandRb = 1'b0;
    chk(!timeoutErr, "R11 flag clear before", timeoutErr, 0);
    push(mk(0, 0, 'h61)); push(mk(0, 5, 0)); push(mk(0, 0, 'h62));
    waitDone();
    chk(timeoutErr, "R11 flag set", timeoutErr, 1);
    chk(evCnt - b == 2 && evIo[b+1] == 8'h62, "R11 continues", evCnt - b, 2);
    push(mk(0, 0, 'h63));
    waitDone();
    chk(timeoutErr, "R11 flag sticky", timeoutErr, 1);
    nandRb = 1'b1;
  endtask

  task automatic t_full();
    int b = evCnt;
    bit seenEE = 0;
    cfgTimeout = 16'd5000; nandRb = 1'b0;
    push(mk(0, 0, 'h01)); push(mk(0, 5, 0));
    repeat (40) @(negedge clk);
    for (int i = 0; i < 32; i++) push(mk(0, 0, i));
    chk(qFull, "R12 full at 32", qFull, 1);
    push(mk(0, 0, 'hEE));
    chk(qFull, "R12 still full", qFull, 1);
    nandRb = 1'b1;
    waitDone();
    for (int i = b; i < evCnt; i++) if (evIo[i] == 8'hEE) seenEE = 1;
    chk(evCnt - b == 33, "R12 executed count", evCnt - b, 33);
    chk(!seenEE && evIo[evCnt-1] == 8'd31, "R12 dropped push", evIo[evCnt-1], 31);
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_cmdAddrWrite();
    t_read();
    t_idle();
    t_twb();
    t_waitBusy();
    t_timeout();
    t_full();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule